// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address with separate write and read strobes and 8-bit data in each direction. Addresses 0, 1 and 2 reach the count register of the channel with that number. Address 3 takes control words, which configure a channel, freeze its count, or run a read-back command across several channels at once.

The block holds each channel's configuration: access width, operating mode and BCD flag. It turns byte writes into 16-bit count loads, steps reads through the low and high bytes, and keeps one-shot snapshots of count and status until the host reads them. The counter datapaths sit outside the block. They receive a registered load strobe with a 16-bit value, the configuration fields, and a pulse whenever a count snapshot is taken. They return their live counts and output levels.

Reads are combinational. While `rd_en` is high, `rdata` shows the byte for the current address, and the clock edge that ends the read cycle advances the byte sequencing. A load strobe and a snapshot pulse are high for the one cycle after the write that caused them.

Top module: `tmr_hostif`

## Requirements
- R1: After reset every channel has access code 3 (low then high), mode 0 and BCD 0. No snapshot is pending, both byte toggles point at the low byte, and `ld_stb` and `snap_req` are zero.
- R2: A control-word write is a write to address 3 whose bits 7:6 are not 3 and whose bits 5:4 are not 0. It sets only the channel named by bits 7:6. The access code comes from bits 5:4, the mode from bits 3:1 and BCD from bit 0. Mode values 6 and 7 are stored as 2 and 3.
- R3: With access code 1, a count write loads {8'h00, byte}.
- R4: With access code 2, a count write loads {byte, 8'h00}.
- R5: With access code 3, the first count write is held and raises no strobe. The second loads {second, first}. The strobe appears on that channel only, in the cycle after the write.
- R6: With no snapshot pending, a read returns the low byte of the live count under code 1 and the high byte under code 2. Under code 3 reads alternate, starting with the low byte.
- R7: A control word with bits 5:4 = 0 snapshots that channel's live count and pulses its `snap_req`. Reads then return the snapshot regardless of later live values. Under code 3 the low byte comes first, then the high byte. Under codes 1 and 2 a single byte is returned. The snapshot is released after its last byte, and reads return to the live count.
- R8: A count or status snapshot request on a channel that still holds an unread snapshot of that kind is ignored, and the first snapshot is kept.
- R9: Read-back is a write to address 3 with bits 7:6 = 3. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 snapshots the count and bit 4 = 0 snapshots the status of every selected channel. Unselected channels are untouched.
- R10: The status byte is {OUT, 1'b0, access code, mode, BCD}. OUT is in bit 7, the access code in bits 5:4, the mode in bits 3:1 and BCD in bit 0. It is captured when the command is written.
- R11: On read, a pending status snapshot is returned first and released. A pending count snapshot comes next, then the live count.
- R12: A control-word write returns that channel's read and write byte toggles to the low byte and drops a held first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0..2 count registers, 3 control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances byte sequencing at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed channel |
| live_cnt | input | 48 | Live counts, channel n in bits 16n+15:16n |
| out_lvl | input | 3 | Counter output levels, one per channel |
| ld_stb | output | 3 | Count load strobe per channel |
| ld_val | output | 48 | Count value to load, channel n in bits 16n+15:16n |
| ch_acc | output | 6 | Access code per channel, 2 bits each |
| ch_mode | output | 9 | Operating mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |
| snap_req | output | 3 | Pulse when a count snapshot is taken |

## Verification
The hardest situation to reach is one where several kinds of pending state overlap on one channel. A read-back has latched both status and count, the live count and OUT levels have since moved, and the byte toggle sits in the middle of a word. The stimulus sets up each channel with a different access code, and fires one read-back command that selects two channels. It then changes every live input before reading, and then drains each channel byte by byte. Repeated latch commands with fresh live data are issued between the snapshot and the reads, to show the first snapshot survives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;

  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL   = 2'd3;
endpackage

// File: rtl/tmr_cmd_dec.sv
module tmr_cmd_dec
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    cfg_we,
  output chcfg_t            cfg_val,
  output logic [NCH-1:0]    cnt_lat,
  output logic [NCH-1:0]    st_lat,
  output logic [NCH-1:0]    dat_we
);
  logic       is_ctl;
  logic       is_rb;
  logic [1:0] sel;
  logic [1:0] acc_f;
  logic [2:0] mode_f;

  always_comb begin
    is_ctl = wr_en && (addr == CTL_ADDR);
    sel    = wdata[7:6];
    is_rb  = (sel == RB_SEL);
    acc_f  = wdata[5:4];
    mode_f = wdata[3:1];
    cfg_val.acc  = acc_e'(acc_f);
    cfg_val.mode = (mode_f[2] && mode_f[1]) ? {1'b0, mode_f[1:0]} : mode_f;
    cfg_val.bcd  = wdata[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    always_comb begin
      dat_we[i]  = wr_en && (addr == 2'(i));
      cfg_we[i]  = is_ctl && !is_rb && (sel == 2'(i)) && (acc_f != 2'd0);
      cnt_lat[i] = is_ctl && (is_rb ? (wdata[i+1] && !wdata[5])
                                    : ((sel == 2'(i)) && (acc_f == 2'd0)));
      st_lat[i]  = is_ctl && is_rb && wdata[i+1] && !wdata[4];
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  chcfg_t              cfg_in,
  input  logic                cnt_lat,
  input  logic                st_lat,
  input  logic                dat_we,
  input  logic                dat_rd,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [2*BYTE_W-1:0] live,
  input  logic                out_lvl,
  output chcfg_t              cfg,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic                ld_stb,
  output logic [2*BYTE_W-1:0] ld_val,
  output logic                snap_req
);
  localparam int CNT_W = 2 * BYTE_W;

  chcfg_t              cfg_q,   cfg_d;
  logic                wr_hi_q, wr_hi_d;
  logic                rd_hi_q, rd_hi_d;
  logic [BYTE_W-1:0]   hold_q,  hold_d;
  acc_e                cl_q,    cl_d;
  logic [CNT_W-1:0]    snap_q,  snap_d;
  logic                sl_q,    sl_d;
  logic [BYTE_W-1:0]   stat_q,  stat_d;
  logic                ldst_q,  ldst_d;
  logic [CNT_W-1:0]    ldv_q,   ldv_d;
  logic                srq_q,   srq_d;

  // read byte selection
  always_comb begin
    if (sl_q) begin
      rd_byte = stat_q;
    end else if (cl_q != ACC_NONE) begin
      rd_byte = (cl_q == ACC_HI) ? snap_q[CNT_W-1:BYTE_W] : snap_q[BYTE_W-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rd_byte = live[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rd_hi_q ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
        default:  rd_byte = live[BYTE_W-1:0];
      endcase
    end
  end

  // next state
  always_comb begin
    cfg_d   = cfg_q;
    wr_hi_d = wr_hi_q;
    rd_hi_d = rd_hi_q;
    hold_d  = hold_q;
    cl_d    = cl_q;
    snap_d  = snap_q;
    sl_d    = sl_q;
    stat_d  = stat_q;
    ldst_d  = 1'b0;
    ldv_d   = ldv_q;
    srq_d   = 1'b0;

    if (cfg_we) begin
      cfg_d   = cfg_in;
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end

    if (dat_we) begin
      unique case (cfg_q.acc)
        ACC_HI: begin
          ldst_d = 1'b1;
          ldv_d  = {wdata, {BYTE_W{1'b0}}};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            hold_d  = wdata;
            wr_hi_d = 1'b1;
          end else begin
            ldst_d  = 1'b1;
            ldv_d   = {wdata, hold_q};
            wr_hi_d = 1'b0;
          end
        end
        default: begin
          ldst_d = 1'b1;
          ldv_d  = {{BYTE_W{1'b0}}, wdata};
        end
      endcase
    end

    if (dat_rd) begin
      if (sl_q) begin
        sl_d = 1'b0;
      end else if (cl_q != ACC_NONE) begin
        cl_d = (cl_q == ACC_WORD) ? ACC_HI : ACC_NONE;
      end else if (cfg_q.acc == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end

    if (cnt_lat && (cl_q == ACC_NONE)) begin
      snap_d = live;
      cl_d   = cfg_q.acc;
      srq_d  = 1'b1;
    end

    if (st_lat && !sl_q) begin
      stat_d = BYTE_W'({out_lvl, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd});
      sl_d   = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      hold_q  <= '0;
      cl_q    <= ACC_NONE;
      snap_q  <= '0;
      sl_q    <= 1'b0;
      stat_q  <= '0;
      ldst_q  <= 1'b0;
      ldv_q   <= '0;
      srq_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      wr_hi_q <= wr_hi_d;
      rd_hi_q <= rd_hi_d;
      hold_q  <= hold_d;
      cl_q    <= cl_d;
      snap_q  <= snap_d;
      sl_q    <= sl_d;
      stat_q  <= stat_d;
      ldst_q  <= ldst_d;
      ldv_q   <= ldv_d;
      srq_q   <= srq_d;
    end
  end

  assign cfg      = cfg_q;
  assign ld_stb   = ldst_q;
  assign ld_val   = ldv_q;
  assign snap_req = srq_q;
endmodule

// File: rtl/tmr_hostif.sv
module tmr_hostif
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  input  logic [NCH*2*BYTE_W-1:0] live_cnt,
  input  logic [NCH-1:0]          out_lvl,
  output logic [NCH-1:0]          ld_stb,
  output logic [NCH*2*BYTE_W-1:0] ld_val,
  output logic [NCH*2-1:0]        ch_acc,
  output logic [NCH*3-1:0]        ch_mode,
  output logic [NCH-1:0]          ch_bcd,
  output logic [NCH-1:0]          snap_req
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [NCH-1:0]    cfg_we, cnt_lat, st_lat, dat_we;
  chcfg_t            cfg_val;
  chcfg_t            cfg   [NCH];
  logic [BYTE_W-1:0] rbyte [NCH];

  tmr_cmd_dec #(.NCH(NCH), .BYTE_W(BYTE_W)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cfg_we  (cfg_we),
    .cfg_val (cfg_val),
    .cnt_lat (cnt_lat),
    .st_lat  (st_lat),
    .dat_we  (dat_we)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic rd_hit;
    assign rd_hit = rd_en && (addr == 2'(i));

    tmr_chan_port #(.BYTE_W(BYTE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[i]),
      .cfg_in   (cfg_val),
      .cnt_lat  (cnt_lat[i]),
      .st_lat   (st_lat[i]),
      .dat_we   (dat_we[i]),
      .dat_rd   (rd_hit),
      .wdata    (wdata),
      .live     (live_cnt[i*CNT_W +: CNT_W]),
      .out_lvl  (out_lvl[i]),
      .cfg      (cfg[i]),
      .rd_byte  (rbyte[i]),
      .ld_stb   (ld_stb[i]),
      .ld_val   (ld_val[i*CNT_W +: CNT_W]),
      .snap_req (snap_req[i])
    );

    assign ch_acc[i*2 +: 2]  = cfg[i].acc;
    assign ch_mode[i*3 +: 3] = cfg[i].mode;
    assign ch_bcd[i]         = cfg[i].bcd;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) rdata = rbyte[i];
    end
  end
endmodule

// File: rtl/tmr_hostif_chk.sv
module tmr_hostif_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [NCH-1:0]   ld_stb,
  input logic [NCH*3-1:0] ch_mode,
  input logic [NCH-1:0]   snap_req
);
  // R5
  ld_single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R3
    ld_after_data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb[i] |-> $past(wr_en && (addr == 2'(i))));

    // R2
    mode_aliased_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[i*3 +: 3] < 3'd6);

    // R2
    mode_only_by_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i*3 +: 3] != $past(ch_mode[i*3 +: 3])) |-> $past(wr_en && (addr == 2'd3)));

    // R7
    snap_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req[i] |-> $past(wr_en && (addr == 2'd3)));
  end
endmodule

bind tmr_hostif tmr_hostif_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .ld_stb   (ld_stb),
  .ch_mode  (ch_mode),
  .snap_req (snap_req)
);

// File: tb/sim_tmr_hostif.sv
`timescale 1ns/1ps
module sim_tmr_hostif;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata, rdata;
  logic [47:0] live_cnt;
  logic [2:0]  out_lvl;
  logic [2:0]  ld_stb;
  logic [47:0] ld_val;
  logic [5:0]  ch_acc;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [2:0]  snap_req;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [1:0] m_acc [3];
  logic [2:0] m_mode[3];
  logic       m_bcd [3];

  always #2 clk = ~clk;

  tmr_hostif u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
    .ld_stb(ld_stb), .ld_val(ld_val), .ch_acc(ch_acc), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .snap_req(snap_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic setlive(input int ch, input logic [15:0] v);
    live_cnt[ch*16 +: 16] = v;
  endtask

  task automatic cfg_chk(input string req);
    for (int c = 0; c < 3; c++) begin
      chk(req, {26'd0, ch_acc[c*2 +: 2], ch_mode[c*3 +: 3], ch_bcd[c]},
               {26'd0, m_acc[c], m_mode[c], m_bcd[c]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, cw;
    rst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    live_cnt = '0; out_lvl = 3'b000;
    for (int c = 0; c < 3; c++) begin m_acc[c] = 2'd3; m_mode[c] = 3'd0; m_bcd[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_chk("R1 cfg after reset");
    chk("R1 ld_stb", {29'd0, ld_stb}, 0);
    chk("R1 snap_req", {29'd0, snap_req}, 0);
    setlive(0, 16'hA1B2);
    rdchk("R1 first read low", 2'd0, 8'hB2);
    rdchk("R6 second read high", 2'd0, 8'hA1);

    // R2 sweep of all control words per channel
    for (int c = 0; c < 3; c++)
      for (int a = 1; a < 4; a++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            cw = {2'(c), 2'(a), 3'(m), 1'(b)};
            wr(2'd3, cw);
            m_acc[c] = 2'(a);
            m_mode[c] = (m >= 6) ? 3'(m - 4) : 3'(m);
            m_bcd[c] = 1'(b);
            cfg_chk("R2 control decode");
          end

    // R3 R4 R5 loads
    for (int c = 0; c < 3; c++) begin
      for (int a = 1; a < 4; a++) begin
        wr(2'd3, {2'(c), 2'(a), 3'd2, 1'b0});
        for (int k = 0; k < 6; k++) begin
          v = 8'(k * 53 + 7);
          wr(2'(c), v);
          if (a == 1) begin
            chk("R3 strobe", {29'd0, ld_stb}, 32'(1 << c));
            chk("R3 value", {16'd0, ld_val[c*16 +: 16]}, {16'd0, 8'h00, v});
          end else if (a == 2) begin
            chk("R4 strobe", {29'd0, ld_stb}, 32'(1 << c));
            chk("R4 value", {16'd0, ld_val[c*16 +: 16]}, {16'd0, v, 8'h00});
          end else begin
            chk("R5 no strobe on first byte", {29'd0, ld_stb}, 0);
            wr(2'(c), ~v);
            chk("R5 strobe", {29'd0, ld_stb}, 32'(1 << c));
            chk("R5 value", {16'd0, ld_val[c*16 +: 16]}, {16'd0, ~v, v});
          end
        end
      end
    end

    // R6 live reads per access code
    for (int c = 0; c < 3; c++) begin
      setlive(c, 16'h5C00 + 16'(c * 17 + 3));
      wr(2'd3, {2'(c), 2'd1, 3'd0, 1'b0});
      rdchk("R6 low only", 2'(c), 8'(c * 17 + 3));
      rdchk("R6 low only again", 2'(c), 8'(c * 17 + 3));
      wr(2'd3, {2'(c), 2'd2, 3'd0, 1'b0});
      rdchk("R6 high only", 2'(c), 8'h5C);
      rdchk("R6 high only again", 2'(c), 8'h5C);
      wr(2'd3, {2'(c), 2'd3, 3'd0, 1'b0});
      for (int k = 0; k < 2; k++) begin
        rdchk("R6 word low", 2'(c), 8'(c * 17 + 3));
        rdchk("R6 word high", 2'(c), 8'h5C);
      end
    end

    // R12 toggles reset by control word
    setlive(1, 16'hC3D4);
    wr(2'd3, 8'h70);
    rdchk("R12 read low", 2'd1, 8'hD4);
    wr(2'd3, 8'h70);
    rdchk("R12 read restarts low", 2'd1, 8'hD4);
    wr(2'd1, 8'h11);
    chk("R12 first byte held", {29'd0, ld_stb}, 0);
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h22);
    chk("R12 write restarts low", {29'd0, ld_stb}, 0);
    wr(2'd1, 8'h33);
    chk("R12 load value", {16'd0, ld_val[31:16]}, 32'h3322);

    // R7 counter latch
    wr(2'd3, 8'h34);
    setlive(0, 16'h1234);
    wr(2'd3, 8'h00);
    chk("R7 snap pulse", {29'd0, snap_req}, 32'b001);
    setlive(0, 16'h9876);
    rdchk("R7 latched low", 2'd0, 8'h34);
    rdchk("R7 latched high", 2'd0, 8'h12);
    rdchk("R7 live low after release", 2'd0, 8'h76);
    rdchk("R7 live high", 2'd0, 8'h98);
    wr(2'd3, 8'h12);
    setlive(0, 16'hABCD);
    wr(2'd3, 8'h00);
    setlive(0, 16'h1111);
    rdchk("R7 latched low-only", 2'd0, 8'hCD);
    rdchk("R7 live after low-only", 2'd0, 8'h11);
    wr(2'd3, 8'h24);
    setlive(0, 16'hABCD);
    wr(2'd3, 8'h00);
    setlive(0, 16'h2222);
    rdchk("R7 latched high-only", 2'd0, 8'hAB);
    rdchk("R7 live after high-only", 2'd0, 8'h22);

    // R8 latch once
    wr(2'd3, 8'hB4);
    setlive(2, 16'h1357);
    wr(2'd3, 8'h80);
    chk("R8 first snap", {29'd0, snap_req}, 32'b100);
    setlive(2, 16'h2468);
    wr(2'd3, 8'h80);
    chk("R8 second latch ignored", {29'd0, snap_req}, 0);
    rdchk("R8 kept low", 2'd2, 8'h57);
    rdchk("R8 kept high", 2'd2, 8'h13);
    rdchk("R8 live after", 2'd2, 8'h68);

    // R9 R10 R11 read-back
    wr(2'd3, 8'h34);
    wr(2'd3, 8'h9B);
    wr(2'd3, 8'h60);
    out_lvl = 3'b101;
    setlive(0, 16'h4321); setlive(1, 16'h0F0E); setlive(2, 16'h8765);
    wr(2'd3, 8'hCA);
    chk("R9 snap on selected", {29'd0, snap_req}, 32'b101);
    out_lvl = 3'b000;
    setlive(0, 16'h0000); setlive(1, 16'h5A5A); setlive(2, 16'h0000);
    rdchk("R10 R11 status first ch0", 2'd0, 8'hB4);
    rdchk("R11 count low ch0", 2'd0, 8'h21);
    rdchk("R11 count high ch0", 2'd0, 8'h43);
    rdchk("R11 live ch0", 2'd0, 8'h00);
    rdchk("R10 R11 status ch2", 2'd2, 8'h9B);
    rdchk("R11 count ch2", 2'd2, 8'h65);
    rdchk("R11 live ch2", 2'd2, 8'h00);
    rdchk("R9 unselected ch1 live", 2'd1, 8'h5A);
    out_lvl = 3'b010;
    wr(2'd3, 8'hE4);
    chk("R9 status only no snap", {29'd0, snap_req}, 0);
    out_lvl = 3'b000;
    wr(2'd3, 8'hE4);
    rdchk("R8 R10 first status kept", 2'd1, 8'hA0);
    rdchk("R11 live after status", 2'd1, 8'h5A);
    setlive(1, 16'h7788);
    wr(2'd3, 8'hD4);
    chk("R9 count only snap", {29'd0, snap_req}, 32'b010);
    setlive(1, 16'h0000);
    rdchk("R9 latched count ch1", 2'd1, 8'h77);
    rdchk("R9 live after ch1", 2'd1, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule